// File: doc/BRIEF.md
# Packet-Atomic Readback Word FIFO

This block buffers 32-bit readback words that arrive from an upstream engine in groups of four. A group is presented on a wide data input together with a one-cycle valid strobe. If the store has room for all four words, all four are written in the same cycle. If it does not, none of them is written and a sticky drop flag is raised so that software can see that data was lost.

Software drains the store through a read-only bus window. Every read request removes one word, and the word comes back on the cycle after the request. A read from an empty store returns zero and leaves the store as it was. A write request into the window changes nothing and raises a one-cycle error response. A free-space count is always visible, and reset leaves the store empty.

Top module: `rdbk_pkt_fifo`

## Requirements
- R1: After reset the free count equals the capacity (2048 by default), the drop flag and bus error are low and the read data is zero.
- R2: The words of an accepted group are popped in lane order: lane 0 (`pkt_data[31:0]`) first, then lane 1, lane 2 and lane 3 (`pkt_data[127:96]`).
- R3: A group is stored only if the free count before that cycle's read is at least four. Otherwise no word of it is stored, and the free count changes only by that cycle's read.
- R4: A discarded group sets `drop_flag` on the next cycle. The flag stays set until `drop_clr` is sampled high. If a discard and a clear fall in the same cycle, the flag ends up set.
- R5: A read request (`bus_req` high, `bus_we` low) to a non-empty store pops the oldest word. The word appears on `bus_rdata` the next cycle and stays there until the next read. The free count rises by one.
- R6: A read request to an empty store returns zero on `bus_rdata` the next cycle and leaves the free count unchanged.
- R7: A write request (`bus_req` and `bus_we` high) drives `bus_err` high for exactly the next cycle. It changes neither the stored words, the free count nor `bus_rdata`.
- R8: A read and an incoming group in the same cycle are both carried out. When the group is accepted, the free count changes by minus three.
- R9: Word order is kept across the wrap of the internal storage over repeated fill and drain cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | A four-word group is offered this cycle |
| pkt_data | input | 128 | Group words, lane 0 in the low 32 bits |
| bus_req | input | 1 | Bus access to the read window |
| bus_we | input | 1 | Access is a write (rejected) |
| bus_rdata | output | 32 | Popped word, valid the cycle after a read |
| bus_err | output | 1 | One-cycle error after a write access |
| drop_clr | input | 1 | Clears the sticky drop flag |
| drop_flag | output | 1 | Sticky: a group was discarded |
| free_cnt | output | 12 | Number of free word entries |

## Verification
The two functions that can fall in the same cycle are a group arriving and a bus read removing a word. The bench provokes both at once at three fill levels: completely full, one entry free, and exactly four entries free. In these cases the room decision must use the count from before the read, so the first two cases must drop the group and the third must accept it. A behavioural queue model predicts the free count, flag, error and read data on every clock, and a discard combined with a flag clear is also provoked and judged against that model.

// File: rtl/rdbk_pkg.sv
package rdbk_pkg;
  // room test: true when free entries can hold a whole group
  function automatic logic has_room(input int unsigned free_words, input int unsigned need);
    return free_words >= need;
  endfunction

  // occupancy after one cycle of optional group write and optional pop
  function automatic int unsigned next_count(input int unsigned cnt, input logic add_grp,
                                             input logic take_one, input int unsigned grp);
    int unsigned n;
    n = cnt + (add_grp ? grp : 0);
    n = n - (take_one ? 1 : 0);
    return n;
  endfunction
endpackage

// File: rtl/rdbk_bank_store.sv
module rdbk_bank_store #(
  parameter int WORD_W    = 32,
  parameter int DEPTH     = 2048,
  parameter int PKT_WORDS = 4,
  localparam int PTR_W    = $clog2(DEPTH),
  localparam int LANE_W   = $clog2(PKT_WORDS),
  localparam int ROW_W    = PTR_W - LANE_W,
  localparam int ROWS     = DEPTH / PKT_WORDS
) (
  input  logic                          clk,
  input  logic                          wr_en,
  input  logic [ROW_W-1:0]              wr_row,
  input  logic [PKT_WORDS*WORD_W-1:0]   wr_data,
  input  logic [PTR_W-1:0]              rd_ptr,
  output logic [WORD_W-1:0]             rd_word
);
  logic [WORD_W-1:0] lane_out [PKT_WORDS];

  // one bank per lane; a group always lands on one row across all banks
  for (genvar g = 0; g < PKT_WORDS; g++) begin : g_bank
    logic [WORD_W-1:0] mem [ROWS];
    always_ff @(posedge clk) begin
      if (wr_en) mem[wr_row] <= wr_data[g*WORD_W +: WORD_W];
    end
    assign lane_out[g] = mem[rd_ptr[PTR_W-1:LANE_W]];
  end

  assign rd_word = lane_out[rd_ptr[LANE_W-1:0]];
endmodule

// File: rtl/rdbk_occupancy.sv
module rdbk_occupancy
  import rdbk_pkg::*;
#(
  parameter int DEPTH     = 2048,
  parameter int PKT_WORDS = 4,
  localparam int PTR_W    = $clog2(DEPTH),
  localparam int LANE_W   = $clog2(PKT_WORDS),
  localparam int ROW_W    = PTR_W - LANE_W,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_valid,
  input  logic             rd_req,
  output logic             accept,
  output logic             drop_evt,
  output logic             pop,
  output logic [ROW_W-1:0] wr_row,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] free_cnt
);
  logic [CNT_W-1:0] cnt_q;
  logic [ROW_W-1:0] row_q;
  logic [PTR_W-1:0] rp_q;
  logic             room;

  assign free_cnt = CNT_W'(DEPTH) - cnt_q;
  assign room     = has_room(32'(free_cnt), PKT_WORDS);
  assign accept   = pkt_valid && room;
  assign drop_evt = pkt_valid && !room;
  assign pop      = rd_req && (cnt_q != '0);
  assign wr_row   = row_q;
  assign rd_ptr   = rp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      row_q <= '0;
      rp_q  <= '0;
    end else begin
      cnt_q <= CNT_W'(next_count(32'(cnt_q), accept, pop, PKT_WORDS));
      if (accept) row_q <= row_q + 1'b1;
      if (pop)    rp_q  <= rp_q + 1'b1;
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> free_cnt >= CNT_W'(PKT_WORDS));
  p_drop_only_short_r3: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |-> free_cnt < CNT_W'(PKT_WORDS));
  p_empty_read_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && free_cnt == CNT_W'(DEPTH) && !pkt_valid) |=> free_cnt == CNT_W'(DEPTH));
  p_idle_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pkt_valid && !rd_req) |=> $stable(free_cnt));
endmodule

// File: rtl/rdbk_bus_port.sv
module rdbk_bus_port #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic              pop,
  input  logic [WORD_W-1:0] head_word,
  output logic              rd_req,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              bus_err
);
  logic wr_req;
  assign rd_req = bus_req && !bus_we;
  assign wr_req = bus_req && bus_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_err <= wr_req;
      if (rd_req) bus_rdata <= pop ? head_word : '0;
    end
  end

  p_err_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> bus_err);
  p_write_keeps_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> $stable(bus_rdata));
  p_empty_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !pop) |=> bus_rdata == '0);
endmodule

// File: rtl/rdbk_pkt_fifo.sv
module rdbk_pkt_fifo #(
  parameter int WORD_W    = 32,
  parameter int DEPTH     = 2048,
  parameter int PKT_WORDS = 4,
  localparam int PTR_W    = $clog2(DEPTH),
  localparam int LANE_W   = $clog2(PKT_WORDS),
  localparam int ROW_W    = PTR_W - LANE_W,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        pkt_valid,
  input  logic [PKT_WORDS*WORD_W-1:0] pkt_data,
  input  logic                        bus_req,
  input  logic                        bus_we,
  output logic [WORD_W-1:0]           bus_rdata,
  output logic                        bus_err,
  input  logic                        drop_clr,
  output logic                        drop_flag,
  output logic [CNT_W-1:0]            free_cnt
);
  logic             accept, drop_evt, pop, rd_req;
  logic [ROW_W-1:0] wr_row;
  logic [PTR_W-1:0] rd_ptr;
  logic [WORD_W-1:0] head_word;

  rdbk_occupancy #(.DEPTH(DEPTH), .PKT_WORDS(PKT_WORDS)) u_occ (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .rd_req(rd_req),
    .accept(accept), .drop_evt(drop_evt), .pop(pop),
    .wr_row(wr_row), .rd_ptr(rd_ptr), .free_cnt(free_cnt));

  rdbk_bank_store #(.WORD_W(WORD_W), .DEPTH(DEPTH), .PKT_WORDS(PKT_WORDS)) u_store (
    .clk(clk), .wr_en(accept), .wr_row(wr_row), .wr_data(pkt_data),
    .rd_ptr(rd_ptr), .rd_word(head_word));

  rdbk_bus_port #(.WORD_W(WORD_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .pop(pop), .head_word(head_word), .rd_req(rd_req),
    .bus_rdata(bus_rdata), .bus_err(bus_err));

  // sticky discard indication; a new discard outranks a clear
  always_ff @(posedge clk) begin
    if (!rst_n)        drop_flag <= 1'b0;
    else if (drop_evt) drop_flag <= 1'b1;
    else if (drop_clr) drop_flag <= 1'b0;
  end

  p_drop_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> drop_flag);
  p_drop_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_flag && !drop_clr) |=> drop_flag);
  p_both_honoured_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && pop) |=> free_cnt == $past(free_cnt) - CNT_W'(PKT_WORDS - 1));
endmodule

// File: tb/rdbk_pkt_fifo_tb.sv
module rdbk_pkt_fifo_tb;
  localparam int DEPTH = 2048;
  localparam int GRP   = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pkt_valid = 1'b0;
  logic [127:0] pkt_data = '0;
  logic         bus_req = 1'b0, bus_we = 1'b0, drop_clr = 1'b0;
  logic [31:0]  bus_rdata;
  logic         bus_err, drop_flag;
  logic [11:0]  free_cnt;

  int checks = 0, fails = 0;
  int unsigned q[$];
  int unsigned exp_rdata = 0;
  bit exp_err = 0, exp_drop = 0;
  int unsigned seq = 32'h1000;

  always #2 clk = ~clk;

  rdbk_pkt_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
    .bus_req(bus_req), .bus_we(bus_we), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .drop_clr(drop_clr), .drop_flag(drop_flag), .free_cnt(free_cnt));

  task automatic chk(input string tag, input string what, input int unsigned act, input int unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [127:0] mkgrp();
    logic [127:0] d;
    for (int i = 0; i < GRP; i++) begin
      d[i*32 +: 32] = seq;
      seq++;
    end
    return d;
  endfunction

  // drive one cycle, advance model, compare after the edge
  task automatic cyc(input logic v, input logic [127:0] d, input logic req,
                     input logic we, input logic clr, input string tag);
    int unsigned fr;
    bit rd;
    pkt_valid = v; pkt_data = d; bus_req = req; bus_we = we; drop_clr = clr;
    fr = DEPTH - q.size();
    rd = req && !we;
    if (rd) exp_rdata = (q.size() > 0) ? q.pop_front() : 0;
    if (v && fr >= GRP) begin
      for (int i = 0; i < GRP; i++) q.push_back(d[i*32 +: 32]);
    end
    if (v && fr < GRP) exp_drop = 1;
    else if (clr) exp_drop = 0;
    exp_err = req && we;
    @(posedge clk);
    @(negedge clk);
    chk(tag, "free_cnt", free_cnt, DEPTH - q.size());
    chk(tag, "drop_flag", drop_flag, exp_drop);
    chk(tag, "bus_err", bus_err, exp_err);
    chk(tag, "bus_rdata", bus_rdata, exp_rdata);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", "free_cnt", free_cnt, DEPTH);
    chk("R1", "drop_flag", drop_flag, 0);
    chk("R1", "bus_err", bus_err, 0);
    chk("R1", "bus_rdata", bus_rdata, 0);
    // R6 empty read
    cyc(0, '0, 1, 0, 0, "R6");
    // R2 / R5 groups in, words out in lane order
    for (int i = 0; i < 3; i++) cyc(1, mkgrp(), 0, 0, 0, "R2");
    for (int i = 0; i < 6; i++) cyc(0, '0, 1, 0, 0, "R5");
    // R7 write rejected mid-stream, then idle after it
    cyc(0, '0, 1, 1, 0, "R7");
    cyc(0, '0, 0, 0, 0, "R7");
    for (int i = 0; i < 7; i++) cyc(0, '0, 1, 0, 0, "R2");
    cyc(1, mkgrp(), 1, 0, 0, "R6");   // empty read, group same cycle
    cyc(0, '0, 1, 1, 0, "R7");
    while (q.size() > 0) cyc(0, '0, 1, 0, 0, "R5");
    // R3 fill completely, then overflow
    while (DEPTH - q.size() >= GRP) cyc(1, mkgrp(), 0, 0, 0, "R3");
    cyc(1, mkgrp(), 0, 0, 0, "R3");
    cyc(0, '0, 0, 0, 0, "R4");
    cyc(0, '0, 0, 0, 1, "R4");
    // R8 read and group together: full -> drop, with clear in same cycle
    cyc(1, mkgrp(), 1, 0, 1, "R8");
    cyc(1, mkgrp(), 1, 0, 0, "R8");   // one free before read -> drop
    cyc(0, '0, 0, 0, 1, "R4");
    cyc(0, '0, 1, 0, 0, "R8");
    cyc(0, '0, 1, 0, 0, "R8");
    cyc(1, mkgrp(), 1, 0, 0, "R8");   // exactly four free -> accept
    // R9 drain across wrap and refill
    while (q.size() > 0) cyc(0, '0, 1, 0, 0, "R9");
    for (int i = 0; i < 5; i++) cyc(1, mkgrp(), 0, 0, 0, "R9");
    while (q.size() > 0) cyc(0, '0, 1, 0, 0, "R9");
    cyc(0, '0, 1, 0, 0, "R6");
    summary();
  end
endmodule